// File: doc/BRIEF.md
# Integration Test Register Bank

This block is a small memory-mapped register bank for checking how a memory controller is wired into a chip. Software uses it to cut the controller off from its surroundings during board-level and integration checks. A single control bit chooses between normal operation and test mode.

In test mode, an 8-bit capture register sends its stored bits to the controller core in place of the live configuration and request pins. A 2-bit override register drives the two sideband outputs in place of the core's own values. In normal mode, the pins and core outputs pass straight through, and reads of the two data registers return the live signals. Writes to the data registers land only while test mode is on. Every access takes exactly one wait state on a simple synchronous slave bus.

Top module: `integ_test_regs`

## Requirements
- R1: After power-on reset, the control bit, the capture register and the override register are all zero. The block is then in normal mode.
- R2: A bus access is seen in its first cycle with `busSel` high. `busReady` goes high in the second cycle, for one cycle only, and a write commits at the end of that cycle. `busRdata` is zero whenever `busReady` is low or the access is a write.
- R3: The control register sits at offset 0xF00. Bit 0 is the test-mode bit (1 = test, 0 = normal). It can be written in either mode and reads back in bit 0.
- R4: In test mode, a read of offset 0xF20 returns the stored capture value in bits [7:0]. The bit layout is: [7:4] chip-select polarities 3..0, [3:2] chip-select-1 width, [1] big-endian enable, [0] self-refresh request. A read of offset 0xF40 returns the stored override value in bits [1:0]: [1] power-pin control, [0] self-refresh acknowledge.
- R5: In normal mode, a read of 0xF20 returns `padCfgIn`, and a read of 0xF40 returns the sideband outputs actually driven, which equal `coreSideIn`.
- R6: Writes to 0xF20 or 0xF40 made in normal mode change nothing. The stored values seen after test mode is entered are the ones from before those writes.
- R7: `coreCfg` equals the stored capture register in test mode and equals `padCfgIn` in normal mode.
- R8: `padSideOut` equals the stored override register in test mode and equals `coreSideIn` in normal mode.
- R9: Reserved upper bits read as zero. An access to any other offset reads zero, completes with the same single wait state and changes no register.
- R10: A bus reset alone (`busRstN` low while `porRstN` stays high) returns all three registers to zero, just as a power-on reset does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porRstN | input | 1 | Power-on reset, active low, asynchronous |
| busRstN | input | 1 | Bus reset, active low, asynchronous |
| busSel | input | 1 | Access request, held until `busReady` |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 12 | Byte offset of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid while `busReady` is high |
| busReady | output | 1 | Access completes in this cycle |
| padCfgIn | input | 8 | Live configuration and request pins |
| coreCfg | output | 8 | Configuration and request bits sent to the core |
| coreSideIn | input | 2 | Sideband output values from the core |
| padSideOut | output | 2 | Sideband outputs driven off the block |

## Verification
A wrong test-mode bit shows up at once. It flips `coreCfg` and `padSideOut` between the pins and the stored values within the same cycle the bit changes. A stored register that is corrupt, or that took a write in normal mode, stays hidden while in normal mode. It appears only in the first cycle after test mode is entered, both on the through paths and on the next read. A wrong wait-state count shows as `busReady` one cycle early or late, or held for two cycles. So the bench compares every output against a behavioural model on every clock, rather than only at read points.

// File: rtl/itb_pkg.sv
package itb_pkg;
  typedef enum logic [1:0] {
    RD_NONE = 2'd0,
    RD_CTRL = 2'd1,
    RD_IN   = 2'd2,
    RD_OUT  = 2'd3
  } rdSel_e;

  typedef struct packed {
    logic   wrCtrl;
    logic   wrIn;
    logic   wrOut;
    rdSel_e rdSel;
  } strobe_t;
endpackage

// File: rtl/itb_ctrl.sv
module itb_ctrl
  import itb_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] CTRL_OFS = 12'hF00,
  parameter logic [ADDR_W-1:0] IN_OFS   = 12'hF20,
  parameter logic [ADDR_W-1:0] OUT_OFS  = 12'hF40
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output logic              busReady,
  output strobe_t           strb
);
  // one wait state: first cycle of access registers the phase, second completes
  logic waitQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      waitQ <= 1'b0;
    else if (waitQ) waitQ <= 1'b0;
    else            waitQ <= busSel;
  end

  assign busReady = waitQ;

  logic live;
  logic hitCtrl, hitIn, hitOut;

  always_comb begin
    live    = waitQ && busSel;
    hitCtrl = (busAddr == CTRL_OFS);
    hitIn   = (busAddr == IN_OFS);
    hitOut  = (busAddr == OUT_OFS);
    strb.wrCtrl = live && busWrite && hitCtrl;
    strb.wrIn   = live && busWrite && hitIn;
    strb.wrOut  = live && busWrite && hitOut;
    strb.rdSel  = RD_NONE;
    if (live && !busWrite) begin
      if (hitCtrl)     strb.rdSel = RD_CTRL;
      else if (hitIn)  strb.rdSel = RD_IN;
      else if (hitOut) strb.rdSel = RD_OUT;
    end
  end

  assert_ready_single_R2: assert property (@(posedge clk) disable iff (!rstN)
    busReady |=> !busReady);
  assert_ready_after_wait_R2: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !busReady) |=> busReady);
endmodule

// File: rtl/itb_datapath.sv
module itb_datapath
  import itb_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IN_W   = 8,
  parameter int OUT_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IN_W-1:0]   padCfgIn,
  input  logic [OUT_W-1:0]  coreSideIn,
  output logic              testMode,
  output logic [IN_W-1:0]   coreCfg,
  output logic [OUT_W-1:0]  padSideOut,
  output logic [DATA_W-1:0] rdata
);
  localparam int IN_PAD  = DATA_W - IN_W;
  localparam int OUT_PAD = DATA_W - OUT_W;

  logic             ctrlQ;
  logic [IN_W-1:0]  inQ;
  logic [OUT_W-1:0] outQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ <= 1'b0;
      inQ   <= '0;
      outQ  <= '0;
    end else begin
      if (strb.wrCtrl)         ctrlQ <= wdata[0];
      if (strb.wrIn  && ctrlQ) inQ   <= wdata[IN_W-1:0];
      if (strb.wrOut && ctrlQ) outQ  <= wdata[OUT_W-1:0];
    end
  end

  assign testMode = ctrlQ;

  // per-bit test multiplexers
  for (genvar i = 0; i < IN_W; i++) begin : g_inMux
    assign coreCfg[i] = ctrlQ ? inQ[i] : padCfgIn[i];
  end
  for (genvar j = 0; j < OUT_W; j++) begin : g_outMux
    assign padSideOut[j] = ctrlQ ? outQ[j] : coreSideIn[j];
  end

  always_comb begin
    unique case (strb.rdSel)
      RD_CTRL: rdata = {{(DATA_W-1){1'b0}}, ctrlQ};
      RD_IN:   rdata = {{IN_PAD{1'b0}}, coreCfg};
      RD_OUT:  rdata = {{OUT_PAD{1'b0}}, padSideOut};
      default: rdata = '0;
    endcase
  end

  assert_in_hold_normal_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrIn && !ctrlQ) |=> $stable(inQ));
  assert_out_hold_normal_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrOut && !ctrlQ) |=> $stable(outQ));
  assert_override_steady_R8: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlQ && !strb.wrOut && !strb.wrCtrl) |=> $stable(padSideOut));
endmodule

// File: rtl/integ_test_regs.sv
module integ_test_regs
  import itb_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int IN_W   = 8,
  parameter int OUT_W  = 2
) (
  input  logic              clk,
  input  logic              porRstN,
  input  logic              busRstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              busReady,
  input  logic [IN_W-1:0]   padCfgIn,
  output logic [IN_W-1:0]   coreCfg,
  input  logic [OUT_W-1:0]  coreSideIn,
  output logic [OUT_W-1:0]  padSideOut
);
  logic    rstN;
  logic    testMode;
  strobe_t strb;

  // either reset source clears the bank
  assign rstN = porRstN & busRstN;

  itb_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .busSel   (busSel),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .busReady (busReady),
    .strb     (strb)
  );

  itb_datapath #(.DATA_W(DATA_W), .IN_W(IN_W), .OUT_W(OUT_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .wdata      (busWdata),
    .padCfgIn   (padCfgIn),
    .coreSideIn (coreSideIn),
    .testMode   (testMode),
    .coreCfg    (coreCfg),
    .padSideOut (padSideOut),
    .rdata      (busRdata)
  );

  assert_cfg_pass_R7: assert property (@(posedge clk) disable iff (!rstN)
    !testMode |-> (coreCfg == padCfgIn));
  assert_side_pass_R8: assert property (@(posedge clk) disable iff (!rstN)
    !testMode |-> (padSideOut == coreSideIn));
  assert_rdata_quiet_R2: assert property (@(posedge clk) disable iff (!rstN)
    !busReady |-> (busRdata == '0));
endmodule

// File: tb/integ_test_regs_tb.sv
module integ_test_regs_tb;
  logic        clk = 1'b0;
  logic        porRstN = 1'b0, busRstN = 1'b1;
  logic        busSel = 1'b0, busWrite = 1'b0;
  logic [11:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        busReady;
  logic [7:0]  padCfgIn = 8'hA5;
  logic [7:0]  coreCfg;
  logic [1:0]  coreSideIn = 2'b01;
  logic [1:0]  padSideOut;

  integer checks = 0, errors = 0;
  bit     done = 0;

  always #2 clk = ~clk;

  integ_test_regs u_dut (.*);

  // behavioural reference model
  bit       refWait = 0, refTest = 0;
  bit [7:0] refIn = 0;
  bit [1:0] refOut = 0;

  always @(posedge clk or negedge porRstN or negedge busRstN) begin
    if (!porRstN || !busRstN) begin
      refWait = 0; refTest = 0; refIn = 0; refOut = 0;
    end else if (refWait) begin
      if (busSel && busWrite) begin
        if (busAddr == 12'hF00) refTest = busWdata[0];
        else if (busAddr == 12'hF20 && refTest) refIn = busWdata[7:0];
        else if (busAddr == 12'hF40 && refTest) refOut = busWdata[1:0];
      end
      refWait = 0;
    end else if (busSel) refWait = 1;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // compare every cycle, mid-period
  always @(negedge clk) begin
    if (porRstN && busRstN && !done) begin
      logic [7:0] expCfg;
      logic [1:0] expSide;
      logic [31:0] expRd;
      string tag;
      expCfg  = refTest ? refIn : padCfgIn;
      expSide = refTest ? refOut : coreSideIn;
      expRd = 0; tag = "R2 rdata idle";
      if (refWait && busSel && !busWrite) begin
        if (busAddr == 12'hF00) begin expRd = {31'b0, refTest}; tag = "R3 ctrl read"; end
        else if (busAddr == 12'hF20) begin expRd = {24'b0, expCfg}; tag = refTest ? "R4 in read" : "R5 in read"; end
        else if (busAddr == 12'hF40) begin expRd = {30'b0, expSide}; tag = refTest ? "R4 out read" : "R5 out read"; end
        else tag = "R9 unmapped read";
      end
      check("R2 ready", {31'b0, busReady}, {31'b0, refWait});
      check("R7 coreCfg", {24'b0, coreCfg}, {24'b0, expCfg});
      check("R8 padSideOut", {30'b0, padSideOut}, {30'b0, expSide});
      check(tag, busRdata, expRd);
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(posedge clk); #1 busSel = 1; busWrite = 1; busAddr = a; busWdata = d;
    @(posedge clk); @(posedge clk); #1 busSel = 0; busWrite = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(posedge clk); #1 busSel = 1; busWrite = 0; busAddr = a;
    @(posedge clk); @(negedge clk); d = busRdata;
    @(posedge clk); #1 busSel = 0;
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk);
    #1 porRstN = 1;
    @(negedge clk);
    check("R1 reset coreCfg pass", {24'b0, coreCfg}, 32'hA5);
    check("R1 reset side pass", {30'b0, padSideOut}, 32'h1);
    rd(12'hF00, v); check("R1 ctrl after reset", v, 0);
    rd(12'hF20, v); check("R5 live pins", v, 32'hA5);
    // writes in normal mode are dropped
    wr(12'hF20, 32'h3C); wr(12'hF40, 32'h3);
    wr(12'hF00, 32'h1);
    rd(12'hF00, v); check("R3 test bit", v, 1);
    rd(12'hF20, v); check("R6 in unchanged", v, 0);
    rd(12'hF40, v); check("R6 out unchanged", v, 0);
    for (int k = 0; k < 6; k++) begin
      wr(12'hF20, 32'h96 ^ (k * 37));
      #1 padCfgIn = 8'h11 * k; coreSideIn = k[1:0];
      wr(12'hF40, {30'b0, k[1:0] ^ 2'b10});
      rd(12'hF20, v); check("R4 in stored", v, (32'h96 ^ (k * 37)) & 32'hFF);
      rd(12'hF40, v); check("R4 out stored", v, {30'b0, k[1:0] ^ 2'b10});
    end
    // other offsets: no effect, read zero
    wr(12'hF24, 32'hFF); wr(12'h004, 32'h0);
    rd(12'h004, v); check("R9 unmapped zero", v, 0);
    rd(12'hF00, v); check("R9 ctrl untouched", v, 1);
    // bus reset alone
    @(posedge clk); #1 busRstN = 0;
    @(posedge clk); #1 busRstN = 1;
    rd(12'hF00, v); check("R10 ctrl after bus reset", v, 0);
    wr(12'hF00, 1);
    rd(12'hF20, v); check("R10 in after bus reset", v, 0);
    wr(12'hF20, 32'h5A); wr(12'hF40, 32'h2);
    @(posedge clk); #1 porRstN = 0;
    @(posedge clk); #1 porRstN = 1;
    rd(12'hF40, v); check("R1 out after power reset", v, {30'b0, coreSideIn});
    for (int k = 0; k < 4; k++) begin
      #1 padCfgIn = 8'hC3 + k; coreSideIn = 2'(k + 1);
      rd(12'hF20, v); check("R5 live pins loop", v, 32'hC3 + k);
      rd(12'hF40, v); check("R5 live side loop", v, {30'b0, 2'(k + 1)});
    end
    repeat (3) @(posedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule